// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block holds the status flags of a combined master/slave I2C controller. The bus engine reports what happens on the wire through single-cycle event strobes. The register file reports accesses through single-cycle access strobes: a transmit holding register write, a receive holding register read, a status register read and a master enable. The unit turns these strobes into an 8-bit status word. Each flag follows its own set, clear-on-event or clear-on-read rule, and the flags interlock. A NACK also makes the transmitter ready, and overrun only clears when the status is read after the transfer has finished. Slave access drops on a NACK or a STOP, and the read-direction bit is forced to 0 whenever there is no slave access.

All strobes are synchronous to `clk`. A strobe seen at a rising edge shows its effect in `status_o` right after that edge, so the effect appears one cycle later. There is no data stream through this block, so every pin is a plain control or status signal with no handshake. `master_mode` selects which set of rules applies and may change between transfers.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset `status_o` is all zero. Bit layout: 0 transfer-done, 1 rx-ready, 2 tx-ready, 3 slave-read, 4 slave-access, 5 general-call, 6 overrun, 7 nack. Every flag changes one cycle after the strobe that causes it.
- R2: In master mode `ev_nack` sets nack, transfer-done and tx-ready in the same next cycle.
- R3: In slave mode `ev_nack` sets nack only while slave-access and slave-read are both 1. During a slave write access nack stays 0.
- R4: Nack and general-call are cleared by `sr_rd`.
- R5: Overrun is set only in master mode, by `ev_rx_byte` while rx-ready is 1. It is cleared only by `sr_rd` while transfer-done is 1. An `sr_rd` at any other time leaves it unchanged.
- R6: General-call is set by `ev_gcall` in slave mode only. In master mode `ev_gcall` has no effect.
- R7: Slave-access is set by `ev_addr_match` in slave mode and cleared by `ev_nack` or `ev_stop`. If a match and a clear event arrive in the same cycle, the match wins.
- R8: Slave-read takes the value of `ev_rw` (1 = master reads) at the address match. It reads as 0 whenever slave-access is 0.
- R9: In master mode tx-ready is cleared by `thr_wr` and set by `ev_shift_load`, `ev_nack` or `master_en`. A set event wins over a write in the same cycle.
- R10: In slave mode tx-ready is cleared by `thr_wr` and set by `ev_ack` or `ev_nack`. A `thr_wr` made while tx-ready and nack are both 1 is ignored. `master_en` has no effect in slave mode.
- R11: Rx-ready is set by `ev_rx_byte` and cleared by `rhr_rd`. The set wins if both arrive in the same cycle.
- R12: Transfer-done is set by `ev_xfer_done` (or by a master-mode `ev_nack`) and cleared by `thr_wr`. The set wins if both arrive in the same cycle.
- R13: When a clear-on-read flag sees its set event and `sr_rd` in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master rules, 0 = slave rules |
| ev_shift_load | input | 1 | Holding byte moved into the shifter |
| ev_rx_byte | input | 1 | Received byte placed in the receive holding register |
| ev_ack | input | 1 | ACK sampled for a transmitted byte |
| ev_nack | input | 1 | NACK sampled for a transmitted byte |
| ev_stop | input | 1 | STOP condition detected |
| ev_addr_match | input | 1 | Received address matched the own slave address |
| ev_gcall | input | 1 | General call address detected |
| ev_rw | input | 1 | Read/write bit of the address byte (1 = read) |
| ev_xfer_done | input | 1 | Transfer complete |
| thr_wr | input | 1 | Transmit holding register write |
| rhr_rd | input | 1 | Receive holding register read |
| sr_rd | input | 1 | Status register read |
| master_en | input | 1 | Master enable strobe |
| status_o | output | 8 | Status word, layout in R1 |

## Verification
The hardest states to reach from the ports are the overrun clear and the blocked slave write. Clearing overrun takes a master-mode byte arriving over an unread byte, then a status read that misses because transfer-done is 0, then a transfer completion, then a second status read. The blocked write needs a slave read access whose byte was NACKed, followed by a holding-register write. Directed sequences build each of these states step by step. They also make set and clear events collide in one cycle. A long run of weighted random strobes then follows, with occasional mode flips, so that mixed interleavings are covered as well.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int B_XFER   = 0;
  localparam int B_RXRDY  = 1;
  localparam int B_TXRDY  = 2;
  localparam int B_SVRD   = 3;
  localparam int B_SVACC  = 4;
  localparam int B_GCALL  = 5;
  localparam int B_OVR    = 6;
  localparam int B_NACK   = 7;

  // simple set/clear cells, index into the cell vector
  localparam int NUM_CELLS = 5;
  typedef enum int {
    C_XFER  = 0,
    C_RXRDY = 1,
    C_GCALL = 2,
    C_OVR   = 3,
    C_NACK  = 4
  } cell_idx_e;
endpackage

// File: rtl/stat_flag_cell.sv
module stat_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/stat_tx_ready.sv
module stat_tx_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic ev_shift_load,
  input  logic ev_ack,
  input  logic ev_nack,
  input  logic master_en,
  input  logic thr_wr,
  input  logic nack_q,
  output logic tx_rdy_o
);
  logic set_m, set_s, set_any, blocked, clr;

  always_comb begin
    set_m   = ev_shift_load | ev_nack | master_en;
    set_s   = ev_ack | ev_nack;
    set_any = master_mode ? set_m : set_s;
    blocked = !master_mode && tx_rdy_o && nack_q;
    clr     = thr_wr && !blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_rdy_o <= 1'b0;
    else if (set_any) tx_rdy_o <= 1'b1;
    else if (clr)     tx_rdy_o <= 1'b0;
  end

  // R9
  master_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (ev_shift_load || ev_nack || master_en)) |=> tx_rdy_o);
  // R10
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && tx_rdy_o && nack_q && thr_wr) |=> tx_rdy_o);
endmodule

// File: rtl/stat_slave_access.sv
module stat_slave_access (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic ev_addr_match,
  input  logic ev_rw,
  input  logic ev_nack,
  input  logic ev_stop,
  output logic sv_acc_o,
  output logic sv_rd_o
);
  logic rd_q, hit;

  assign hit = ev_addr_match && !master_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_acc_o <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (hit) begin
        sv_acc_o <= 1'b1;
        rd_q     <= ev_rw;
      end else if (ev_nack || ev_stop) begin
        sv_acc_o <= 1'b0;
      end
    end
  end

  assign sv_rd_o = rd_q & sv_acc_o;

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_nack || ev_stop) && !hit) |=> !sv_acc_o);
  // R8
  dir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (sv_acc_o && (sv_rd_o == $past(ev_rw))));
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              ev_shift_load,
  input  logic              ev_rx_byte,
  input  logic              ev_ack,
  input  logic              ev_nack,
  input  logic              ev_stop,
  input  logic              ev_addr_match,
  input  logic              ev_gcall,
  input  logic              ev_rw,
  input  logic              ev_xfer_done,
  input  logic              thr_wr,
  input  logic              rhr_rd,
  input  logic              sr_rd,
  input  logic              master_en,
  output logic [STAT_W-1:0] status_o
);
  logic [NUM_CELLS-1:0] set_v, clr_v, q_v;
  logic sv_acc, sv_rd, tx_rdy;

  always_comb begin
    set_v[C_XFER]  = ev_xfer_done | (master_mode & ev_nack);
    clr_v[C_XFER]  = thr_wr;
    set_v[C_RXRDY] = ev_rx_byte;
    clr_v[C_RXRDY] = rhr_rd;
    set_v[C_GCALL] = ev_gcall & ~master_mode;
    clr_v[C_GCALL] = sr_rd;
    set_v[C_OVR]   = master_mode & ev_rx_byte & q_v[C_RXRDY];
    clr_v[C_OVR]   = sr_rd & q_v[C_XFER];
    set_v[C_NACK]  = ev_nack & (master_mode | (sv_acc & sv_rd));
    clr_v[C_NACK]  = sr_rd;
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    stat_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  stat_slave_access u_sacc (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_mode   (master_mode),
    .ev_addr_match (ev_addr_match),
    .ev_rw         (ev_rw),
    .ev_nack       (ev_nack),
    .ev_stop       (ev_stop),
    .sv_acc_o      (sv_acc),
    .sv_rd_o       (sv_rd)
  );

  stat_tx_ready u_txr (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_mode   (master_mode),
    .ev_shift_load (ev_shift_load),
    .ev_ack        (ev_ack),
    .ev_nack       (ev_nack),
    .master_en     (master_en),
    .thr_wr        (thr_wr),
    .nack_q        (q_v[C_NACK]),
    .tx_rdy_o      (tx_rdy)
  );

  always_comb begin
    status_o          = '0;
    status_o[B_XFER]  = q_v[C_XFER];
    status_o[B_RXRDY] = q_v[C_RXRDY];
    status_o[B_TXRDY] = tx_rdy;
    status_o[B_SVRD]  = sv_rd;
    status_o[B_SVACC] = sv_acc;
    status_o[B_GCALL] = q_v[C_GCALL];
    status_o[B_OVR]   = q_v[C_OVR];
    status_o[B_NACK]  = q_v[C_NACK];
  end

  // R2
  master_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ev_nack) |=> (status_o[B_NACK] && status_o[B_XFER] && status_o[B_TXRDY]));
  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !status_o[B_XFER] && !ev_rx_byte) |=> $stable(status_o[B_OVR]));
  // R3
  slave_write_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !status_o[B_SVRD] && !status_o[B_NACK] && !sr_rd) |=> !status_o[B_NACK]);
  // R6
  gcall_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !status_o[B_GCALL]) |=> !status_o[B_GCALL]);
endmodule

// File: tb/i2c_stat_flags_bench.sv
module i2c_stat_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic master_mode, ev_shift_load, ev_rx_byte, ev_ack, ev_nack, ev_stop;
  logic ev_addr_match, ev_gcall, ev_rw, ev_xfer_done;
  logic thr_wr, rhr_rd, sr_rd, master_en;
  logic [7:0] status_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference flags
  bit m_xfer, m_rx, m_tx, m_srd, m_sacc, m_gc, m_ovr, m_nack;

  string bit_req[8] = '{"R12", "R11", "R9/R10", "R8", "R7", "R6", "R5", "R2/R3"};

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_flags u_i2c_stat_flags (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .ev_shift_load(ev_shift_load), .ev_rx_byte(ev_rx_byte), .ev_ack(ev_ack),
    .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_addr_match(ev_addr_match),
    .ev_gcall(ev_gcall), .ev_rw(ev_rw), .ev_xfer_done(ev_xfer_done),
    .thr_wr(thr_wr), .rhr_rd(rhr_rd), .sr_rd(sr_rd), .master_en(master_en),
    .status_o(status_o)
  );

  function automatic logic [7:0] model_word();
    return {m_nack, m_ovr, m_gc, m_sacc, m_srd & m_sacc, m_tx, m_rx, m_xfer};
  endfunction

  task automatic clear_strobes();
    ev_shift_load = 0; ev_rx_byte = 0; ev_ack = 0; ev_nack = 0; ev_stop = 0;
    ev_addr_match = 0; ev_gcall = 0; ev_rw = 0; ev_xfer_done = 0;
    thr_wr = 0; rhr_rd = 0; sr_rd = 0; master_en = 0;
  endtask

  task automatic model_update();
    bit vis_rd;
    bit n_xfer, n_rx, n_tx, n_srd, n_sacc, n_gc, n_ovr, n_nack;
    vis_rd = m_srd & m_sacc;
    n_xfer = m_xfer; n_rx = m_rx; n_tx = m_tx; n_srd = m_srd;
    n_sacc = m_sacc; n_gc = m_gc; n_ovr = m_ovr; n_nack = m_nack;
    // R12 transfer done
    if (ev_xfer_done || (master_mode && ev_nack)) n_xfer = 1;
    else if (thr_wr) n_xfer = 0;
    // R11 receive ready
    if (ev_rx_byte) n_rx = 1;
    else if (rhr_rd) n_rx = 0;
    // R6 general call
    if (!master_mode && ev_gcall) n_gc = 1;
    else if (sr_rd) n_gc = 0;
    // R5 overrun
    if (master_mode && ev_rx_byte && m_rx) n_ovr = 1;
    else if (sr_rd && m_xfer) n_ovr = 0;
    // R2 R3 nack
    if (ev_nack && (master_mode || (m_sacc && vis_rd))) n_nack = 1;
    else if (sr_rd) n_nack = 0;
    // R9 R10 transmit ready
    if (master_mode) begin
      if (ev_shift_load || ev_nack || master_en) n_tx = 1;
      else if (thr_wr) n_tx = 0;
    end else begin
      if (ev_ack || ev_nack) n_tx = 1;
      else if (thr_wr && !(m_tx && m_nack)) n_tx = 0;
    end
    // R7 R8 slave access
    if (!master_mode && ev_addr_match) begin
      n_sacc = 1; n_srd = ev_rw;
    end else if (ev_nack || ev_stop) n_sacc = 0;
    m_xfer = n_xfer; m_rx = n_rx; m_tx = n_tx; m_srd = n_srd;
    m_sacc = n_sacc; m_gc = n_gc; m_ovr = n_ovr; m_nack = n_nack;
  endtask

  // strobes must already be set (after a negedge); one clock, then compare
  task automatic step(string tag);
    logic [7:0] exp;
    @(posedge clk);
    model_update();
    #1;
    exp = model_word();
    checks++;
    for (int b = 0; b < 8; b++) begin
      if (status_o[b] !== exp[b]) begin
        failures++;
        $display("FAIL %s bit%0d (%s): status=%b expected=%b", tag, b, bit_req[b], status_o, exp);
      end
    end
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic expect_bit(string tag, int b, bit v);
    checks++;
    if (status_o[b] !== v) begin
      failures++;
      $display("FAIL %s bit%0d: actual=%b expected=%b", tag, b, status_o[b], v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_strobes();
    master_mode = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (status_o !== 8'h00) begin
      failures++;
      $display("FAIL R1 reset: actual=%h expected=00", status_o);
    end
    rst_n = 1;
    @(negedge clk);

    // ---- master mode ----
    master_en = 1; step("R9 enable");
    expect_bit("R9 tx after enable", 2, 1);
    thr_wr = 1; step("R9 thr write");
    expect_bit("R9 tx cleared", 2, 0);
    ev_shift_load = 1; thr_wr = 1; step("R9 set wins");
    ev_nack = 1; step("R2 master nack");
    expect_bit("R2 nack", 7, 1); expect_bit("R2 xfer", 0, 1);
    ev_rx_byte = 1; sr_rd = 1; step("R13 read collides");
    ev_rx_byte = 1; step("R5 overrun set");
    expect_bit("R5 ovr", 6, 1);
    thr_wr = 1; step("R12 xfer clear");
    sr_rd = 1; step("R5 read without xfer");
    expect_bit("R5 ovr kept", 6, 1);
    ev_xfer_done = 1; thr_wr = 1; step("R12 set wins");
    sr_rd = 1; step("R5 read with xfer");
    expect_bit("R5 ovr cleared", 6, 0);
    ev_rx_byte = 1; rhr_rd = 1; step("R11 set wins");
    rhr_rd = 1; step("R11 read clears");
    ev_gcall = 1; step("R6 gcall ignored in master");
    expect_bit("R6 gcall", 5, 0);

    // ---- slave mode ----
    master_mode = 0; sr_rd = 1; step("R4 nack read clear");
    ev_addr_match = 1; ev_rw = 0; step("R8 write access");
    ev_nack = 1; ev_addr_match = 1; step("R7 match wins");
    ev_nack = 1; step("R3 slave write nack");
    expect_bit("R3 no nack", 7, 0);
    expect_bit("R7 dropped", 4, 0);
    expect_bit("R8 rd zero", 3, 0);
    ev_addr_match = 1; ev_rw = 1; step("R8 read access");
    thr_wr = 1; step("R10 slave write");
    ev_ack = 1; step("R10 ack");
    thr_wr = 1; step("R10 write again");
    ev_nack = 1; step("R3 slave read nack");
    expect_bit("R3 nack", 7, 1);
    thr_wr = 1; step("R10 blocked write");
    expect_bit("R10 tx held", 2, 1);
    master_en = 1; sr_rd = 1; step("R10 enable ignored");
    ev_addr_match = 1; step("R7 reacquire");
    ev_stop = 1; step("R7 stop");
    ev_gcall = 1; sr_rd = 1; step("R13 gcall collides");
    sr_rd = 1; step("R4 gcall read");

    // ---- random ----
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 99) < 3) master_mode = ~master_mode;
      ev_shift_load = ($urandom_range(0, 7) == 0);
      ev_rx_byte    = ($urandom_range(0, 5) == 0);
      ev_ack        = ($urandom_range(0, 7) == 0);
      ev_nack       = ($urandom_range(0, 11) == 0);
      ev_stop       = ($urandom_range(0, 15) == 0);
      ev_addr_match = ($urandom_range(0, 7) == 0);
      ev_gcall      = ($urandom_range(0, 11) == 0);
      ev_rw         = $urandom_range(0, 1);
      ev_xfer_done  = ($urandom_range(0, 9) == 0);
      thr_wr        = ($urandom_range(0, 5) == 0);
      rhr_rd        = ($urandom_range(0, 5) == 0);
      sr_rd         = ($urandom_range(0, 4) == 0);
      master_en     = ($urandom_range(0, 19) == 0);
      step("R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule